// File: doc/BRIEF.md
# Boundary-Scan Three-State Pin Cell Chain

This block is one section of a device's boundary-scan data register. It sits between the core logic and a group of bidirectional pads, plus a few input-only pads. It gives the test access port a serial path that can observe every pad and, in external-test mode, drive every pad. Each bidirectional pin owns three cells. The first is a control cell, where a 1 turns the pad driver off. The second is an output cell that holds the level to drive. The third is an input cell that only observes the pad. An input-only pin owns a single observing cell. Filler cells with no pin behind them pad the chain to its fixed length.

The TAP controller supplies the capture, shift and update strobes and an external-test flag, all sampled on the rising edge of the test clock. When the flag is low, the pads follow the core and the chain can observe them without disturbing anything. When the flag is high, the pads are driven from the update latches.

Top module: `bscan_pin_chain`

## Requirements
- R1: The chain has NUM_FILL + 3*NUM_PINS + NUM_IN cells, with position 0 nearest `tdi`. Positions 0 to NUM_FILL-1 are filler cells. Pin p then owns positions NUM_FILL+3p (control), NUM_FILL+3p+1 (output) and NUM_FILL+3p+2 (input). The input-only pins follow these, and `tdo` shows the last cell.
- R2: On a rising edge with `capture_dr` high, each cell loads a value. A control cell loads the inverse of `core_oe`, an output cell loads `core_out`, a pin's input cell loads `pad_in`, an input-only cell loads `in_pad`, and a filler cell loads 0.
- R3: On a rising edge with `shift_dr` high and `capture_dr` low, every cell takes the value of its neighbour nearer `tdi`, and position 0 takes `tdi`.
- R4: On a rising edge with `update_dr` high, the control and output latches load from their chain cells, and at all other times they hold. Input cells and filler cells have no latch, so their contents never reach a pad.
- R5: While `extest` is low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`, whatever the latches hold.
- R6: While `extest` is high, `pad_out` equals the output latch and `pad_oe` is the inverse of the control latch, so a latched 1 leaves the pad undriven.
- R7: After reset, every control latch holds 1 and every output latch holds 0. The chain holds its safe values: 1 in control cells and 0 in all other cells.
- R8: `core_in` follows `pad_in` and `in_core` follows `in_pad` in both modes.
- R9: When `capture_dr` and `shift_dr` are both high, capture wins. When no strobe is high, the chain holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (last cell) |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| extest | input | 1 | External-test mode flag |
| core_out | input | NUM_PINS | Core output levels |
| core_oe | input | NUM_PINS | Core output enables, 1 = drive |
| core_in | output | NUM_PINS | Pad levels to core |
| pad_out | output | NUM_PINS | Levels to pad drivers |
| pad_oe | output | NUM_PINS | Pad driver enables, 1 = drive |
| pad_in | input | NUM_PINS | Levels from bidirectional pads |
| in_pad | input | NUM_IN | Levels from input-only pads |
| in_core | output | NUM_IN | Input-only levels to core |

## Verification
A wrong cell order or a wrong captured value shows up on `tdo` within one full scan, NUM_FILL + 3*NUM_PINS + NUM_IN clocks after the capture. A latch that loads at the wrong time, or loads from the wrong cell, shows on `pad_out`/`pad_oe` in the cycle after the update, but only while `extest` is high. Because of this, the sweeps check the pads both before and after each update. Errors in the mode mux or the pass-through show at once on the pads, without any clock.

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain #(
  parameter int NUM_PINS = 3,
  parameter int NUM_IN   = 1,
  parameter int NUM_FILL = 2
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tdi,
  output logic                tdo,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                extest,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] core_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_IN-1:0]   in_pad,
  output logic [NUM_IN-1:0]   in_core
);
  localparam int PIN_BASE = NUM_FILL;
  localparam int IN_BASE  = NUM_FILL + 3 * NUM_PINS;
  localparam int LEN      = IN_BASE + NUM_IN;

  logic [LEN-1:0]      chain, cap_val, safe_val;
  logic [NUM_PINS-1:0] ctl_cell, out_cell, ctl_lat, out_lat;

  for (genvar f = 0; f < NUM_FILL; f++) begin : g_fill
    assign cap_val[f]  = 1'b0;
    assign safe_val[f] = 1'b0;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int B = PIN_BASE + 3 * p;
    assign ctl_cell[p]     = chain[B];
    assign out_cell[p]     = chain[B+1];
    assign cap_val[B]      = ~core_oe[p];
    assign cap_val[B+1]    = core_out[p];
    assign cap_val[B+2]    = pad_in[p];
    assign safe_val[B]     = 1'b1;
    assign safe_val[B+1]   = 1'b0;
    assign safe_val[B+2]   = 1'b0;
  end

  for (genvar j = 0; j < NUM_IN; j++) begin : g_inonly
    assign cap_val[IN_BASE+j]  = in_pad[j];
    assign safe_val[IN_BASE+j] = 1'b0;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         chain <= safe_val;
    else if (capture_dr) chain <= cap_val;
    else if (shift_dr)   chain <= {chain[LEN-2:0], tdi};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ctl_lat <= '1;
      out_lat <= '0;
    end else if (update_dr) begin
      ctl_lat <= ctl_cell;
      out_lat <= out_cell;
    end
  end

  assign tdo     = chain[LEN-1];
  assign pad_out = extest ? out_lat : core_out;
  assign pad_oe  = extest ? ~ctl_lat : core_oe;
  assign core_in = pad_in;
  assign in_core = in_pad;

  // R2
  ctl_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr |=> ctl_cell == ~$past(core_oe));

  // R3
  shift_move_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr) |=> tdo == $past(chain[LEN-2]));

  // R4
  latch_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> ($stable(ctl_lat) && $stable(out_lat)));

  // R6
  extest_drive_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && extest) |=> (!extest || (pad_oe == ~$past(ctl_cell) && pad_out == $past(out_cell))));

  // R9
  chain_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!capture_dr && !shift_dr) |=> $stable(chain));
endmodule

// File: tb/bscan_pin_chain_tb_top.sv
module bscan_pin_chain_tb_top;
  localparam int NP = 3, NI = 1, NF = 2;
  localparam int L = NF + 3 * NP + NI;

  logic tck = 0, trst_n = 0, tdi = 0, tdo;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, extest = 0;
  logic [NP-1:0] core_out = '0, core_oe = '0, core_in, pad_out, pad_oe, pad_in = '0;
  logic [NI-1:0] in_pad = '0, in_core;
  int checks = 0, errors = 0;

  bscan_pin_chain #(.NUM_PINS(NP), .NUM_IN(NI), .NUM_FILL(NF)) dut_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr), .extest(extest),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
    .in_pad(in_pad), .in_core(in_core));

  always #5 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic cap, input logic sh, input logic up, input logic d);
    @(negedge tck);
    capture_dr = cap; shift_dr = sh; update_dr = up; tdi = d;
    @(posedge tck); #1;
    capture_dr = 0; shift_dr = 0; update_dr = 0;
  endtask

  task automatic scan(input logic [L-1:0] vin, output logic [L-1:0] vout);
    for (int k = 0; k < L; k++) begin
      vout[L-1-k] = tdo;
      step(0, 1, 0, vin[L-1-k]);
    end
  endtask

  function automatic logic [L-1:0] cap_exp(input logic [NP-1:0] oe, out, pi, input logic [NI-1:0] ip);
    logic [L-1:0] v = '0;
    for (int p = 0; p < NP; p++) begin
      v[NF+3*p] = ~oe[p]; v[NF+3*p+1] = out[p]; v[NF+3*p+2] = pi[p];
    end
    for (int j = 0; j < NI; j++) v[NF+3*NP+j] = ip[j];
    return v;
  endfunction

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [L-1:0] got, safe, vin, e;
    logic [NP-1:0] lat_out, lat_ctl;
    safe = '0;
    for (int p = 0; p < NP; p++) safe[NF+3*p] = 1'b1;
    #23 trst_n = 1;

    // R7 reset state, seen in external-test mode and on the chain
    extest = 1; #1;
    chk(pad_oe == '0, "R7 pad_oe after reset", pad_oe, 0);
    chk(pad_out == '0, "R7 pad_out after reset", pad_out, 0);
    scan('0, got);
    chk(got == safe, "R7/R1 safe chain", got, safe);
    extest = 0;

    // R2/R1/R5/R8 exhaustive capture sweep
    for (int i = 0; i < 1024; i++) begin
      core_oe = i[2:0]; core_out = i[5:3]; pad_in = i[8:6]; in_pad = i[9];
      #1;
      chk(pad_oe == core_oe && pad_out == core_out, "R5 pass-through",
          {pad_oe, pad_out}, {core_oe, core_out});
      chk(core_in == pad_in && in_core == in_pad, "R8 input feed",
          {core_in, in_core}, {pad_in, in_pad});
      step(1, 0, 0, 0);
      scan('0, got);
      e = cap_exp(core_oe, core_out, pad_in, in_pad);
      chk(got == e, "R2 captured chain", got, e);
    end

    // R9 capture wins over shift
    core_oe = 3'b101; core_out = 3'b011; pad_in = 3'b110; in_pad = 1'b1;
    step(1, 1, 0, 1);
    scan('0, got);
    e = cap_exp(core_oe, core_out, pad_in, in_pad);
    chk(got == e, "R9 capture priority", got, e);
    step(0, 0, 0, 1);
    chk(tdo == 1'b0, "R9 idle hold", tdo, 0);

    // R3/R4/R6 external-test sweep
    extest = 1;
    lat_ctl = '1; lat_out = '0;
    for (int v = 0; v < 64; v++) begin
      vin = '0;
      for (int p = 0; p < NP; p++) begin
        vin[NF+3*p] = v[p]; vin[NF+3*p+1] = v[3+p]; vin[NF+3*p+2] = ~v[p];
      end
      for (int f = 0; f < NF; f++) vin[f] = v[f];
      vin[L-1] = v[5];
      scan(vin, got);
      chk(pad_oe == ~lat_ctl && pad_out == lat_out, "R4 pads hold before update",
          {pad_oe, pad_out}, {~lat_ctl, lat_out});
      step(0, 0, 1, 0);
      lat_ctl = v[2:0]; lat_out = v[5:3];
      chk(pad_oe == ~lat_ctl, "R6 pad_oe from control latch", pad_oe, ~lat_ctl);
      chk(pad_out == lat_out, "R6 pad_out from output latch", pad_out, lat_out);
      scan('0, got);
      chk(got == vin, "R3 shift-through", got, vin);
      chk(pad_oe == ~lat_ctl && pad_out == lat_out, "R4 input/filler cells have no latch",
          {pad_oe, pad_out}, {~lat_ctl, lat_out});
    end

    // R5 mode flag off ignores latches
    extest = 0; core_oe = 3'b010; core_out = 3'b100; #1;
    chk(pad_oe == 3'b010 && pad_out == 3'b100, "R5 latches ignored",
        {pad_oe, pad_out}, {3'b010, 3'b100});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule